// File: doc/BRIEF.md
# Core Voltage Reference Decoder and Power-Good Monitor

This block turns a 5-bit voltage-identification code into the core regulator's reference level in millivolts. It also flags the codes that must shut the controller down. On every clock it compares a sampled core sense voltage against windows scaled from that reference. From that comparison it produces a power-good output with hysteresis on both edges of the window, and an over-voltage flag.

The code map is not monotonic. Two ranges use different step sizes, and the inhibit codes are scattered between them. All thresholds are integer percentages of the decoded reference. Power-good also needs two external flags to be high. Each flag reports that one of the linear outputs is above its under-voltage level.

Top module: `vid_pgood_mon`

## Requirements
- R1: Codes 5'b00000 to 5'b00101 (vid[4] is the MSB) decode to 2050 mV minus 50 mV per code step. So 00000 gives 2050 mV and 00101 gives 1800 mV.
- R2: Codes 5'b10000 to 5'b11110 decode to 100 mV steps. 11110 gives 2100 mV and each lower code adds 100 mV, up to 3500 mV at 10000.
- R3: Code 11111, codes matching 01xxx and codes matching 0011x set inhibit = 1. They also give ref_mv = 0, release pgood (pgood = 1), clear ov, and clear both window states.
- R4: pgood is 0 whenever rail_a_ok or rail_b_ok was 0 at the sampling edge and the code is not an inhibit code.
- R5: The upper window state sets when sense_mv is greater than 110% of the reference. It clears when sense_mv is less than 108%, and holds in between. While it is set, pgood is 0.
- R6: The lower window state sets when sense_mv is greater than 94% of the reference. It clears when sense_mv is less than 92%, and holds in between. While it is clear, pgood is 0.
- R7: ov is 1 exactly when sense_mv is greater than 115% of the reference at the sampling edge and the code is not an inhibit code.
- R8: While rst_n is low, ref_mv = 0, inhibit = 0, pgood = 0 and ov = 0, and both window states are clear.
- R9: All outputs are registered with one clock of latency. A new code updates ref_mv at the next edge, and the window comparison at that same edge already uses the new reference.
- R10: Every threshold equals floor(reference × percent / 100), and the comparisons are strict. At 2050 mV, for example, 2255 does not set the upper state and 2256 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid | input | 5 | Voltage-identification code, bit 4 most significant |
| sense_mv | input | MV_W | Sampled core sense voltage in mV |
| rail_a_ok | input | 1 | First linear output is above its under-voltage level |
| rail_b_ok | input | 1 | Second linear output is above its under-voltage level |
| ref_mv | output | MV_W | Decoded reference in mV, 0 while inhibited |
| inhibit | output | 1 | Current code disables the controller |
| pgood | output | 1 | Power good, released high while inhibited |
| ov | output | 1 | Core over-voltage |

## Verification
The assertions check, on every cycle, that an inhibit code releases power-good and clears ov and the reference. They also check that ov and power-good are never high together, that power-good implies the sense value lay inside the outer hysteresis bounds with both linear flags high, and that the reference of any active code lies on the 50 mV grid between 1800 and 3500 mV. Some behaviour needs a history of inputs and only the bench's scenarios can show it. This covers the hysteresis itself, where the same sense value gives different results depending on the path taken. It also covers the exact floor-rounded boundaries and the case where a code change moves the window under a held sense value in the same clock.

// File: rtl/vidmon_pkg.sv
`timescale 1ns/1ps
package vidmon_pkg;
  localparam int VID_W = 5;

  // floor(mv * pct / 100)
  function automatic int unsigned pct_floor(input int unsigned mv, input int unsigned pct);
    return (mv * pct) / 100;
  endfunction

  // controller-disabling codes
  function automatic logic code_inhibits(input logic [VID_W-1:0] code);
    return (code == 5'b11111) || (code[4:3] == 2'b01) || (code[4:1] == 4'b0011);
  endfunction

  // reference in mV; 0 for inhibit codes
  function automatic int unsigned code_ref_mv(input logic [VID_W-1:0] code);
    int unsigned c;
    c = 32'(code);
    if (code_inhibits(code)) return 0;
    if (code[4]) return 5100 - c * 100;
    return 2050 - c * 50;
  endfunction
endpackage

// File: rtl/vid_ref_decode.sv
`timescale 1ns/1ps
module vid_ref_decode #(
  parameter int MV_W = 13
)(
  input  logic [vidmon_pkg::VID_W-1:0] vid,
  output logic [MV_W-1:0]              ref_mv,
  output logic                         inhibit
);
  always_comb begin
    inhibit = vidmon_pkg::code_inhibits(vid);
    ref_mv  = MV_W'(vidmon_pkg::code_ref_mv(vid));
  end
endmodule

// File: rtl/hyst_cmp.sv
`timescale 1ns/1ps
module hyst_cmp #(
  parameter int MV_W = 13
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [MV_W-1:0] sample,
  input  logic [MV_W-1:0] set_th,
  input  logic [MV_W-1:0] clr_th,
  output logic            state_next
);
  logic state_q;

  always_comb begin
    if (clear)                 state_next = 1'b0;
    else if (sample > set_th)  state_next = 1'b1;
    else if (sample < clr_th)  state_next = 1'b0;
    else                       state_next = state_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= state_next;
  end
endmodule

// File: rtl/vid_pgood_mon.sv
`timescale 1ns/1ps
module vid_pgood_mon #(
  parameter int MV_W    = 13,
  parameter int OV_PCT  = 115,
  parameter int HI_PCT  = 110,
  parameter int LO_PCT  = 94,
  parameter int HYS_PCT = 2
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [vidmon_pkg::VID_W-1:0] vid,
  input  logic [MV_W-1:0]              sense_mv,
  input  logic                         rail_a_ok,
  input  logic                         rail_b_ok,
  output logic [MV_W-1:0]              ref_mv,
  output logic                         inhibit,
  output logic                         pgood,
  output logic                         ov
);
  localparam int NWIN   = 2;
  localparam int WIN_HI = 0;
  localparam int WIN_LO = 1;

  logic [MV_W-1:0] dec_ref;
  logic            dec_inh;
  logic [NWIN-1:0] win_next;
  logic [MV_W-1:0] ov_th;
  logic            hi_next, lo_next, pg_next, ov_next;

  vid_ref_decode #(.MV_W(MV_W)) u_dec (
    .vid     (vid),
    .ref_mv  (dec_ref),
    .inhibit (dec_inh)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int P_SET = (g == WIN_HI) ? HI_PCT : LO_PCT;
    localparam int P_CLR = P_SET - HYS_PCT;
    logic [MV_W-1:0] th_set, th_clr;
    assign th_set = MV_W'(vidmon_pkg::pct_floor(32'(dec_ref), P_SET));
    assign th_clr = MV_W'(vidmon_pkg::pct_floor(32'(dec_ref), P_CLR));
    hyst_cmp #(.MV_W(MV_W)) u_hys (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (dec_inh),
      .sample     (sense_mv),
      .set_th     (th_set),
      .clr_th     (th_clr),
      .state_next (win_next[g])
    );
  end

  assign ov_th   = MV_W'(vidmon_pkg::pct_floor(32'(dec_ref), OV_PCT));
  assign hi_next = win_next[WIN_HI];
  assign lo_next = win_next[WIN_LO];
  assign pg_next = dec_inh | (lo_next & ~hi_next & rail_a_ok & rail_b_ok);
  assign ov_next = ~dec_inh & (sense_mv > ov_th);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_mv  <= '0;
      inhibit <= 1'b0;
      pgood   <= 1'b0;
      ov      <= 1'b0;
    end else begin
      ref_mv  <= dec_ref;
      inhibit <= dec_inh;
      pgood   <= pg_next;
      ov      <= ov_next;
    end
  end
endmodule

// File: rtl/vid_pgood_mon_chk.sv
`timescale 1ns/1ps
module vid_pgood_mon_chk #(
  parameter int MV_W    = 13,
  parameter int HI_PCT  = 110,
  parameter int LO_PCT  = 94,
  parameter int HYS_PCT = 2
)(
  input logic                         clk,
  input logic                         rst_n,
  input logic [vidmon_pkg::VID_W-1:0] vid,
  input logic [MV_W-1:0]              sense_mv,
  input logic                         rail_a_ok,
  input logic                         rail_b_ok,
  input logic [MV_W-1:0]              ref_mv,
  input logic                         inhibit,
  input logic                         pgood,
  input logic                         ov
);
  a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pgood && !ov && !inhibit && ref_mv == '0));

  a_r3_inhibit_releases: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (pgood && !ov && ref_mv == '0));

  a_r7_ov_blocks_pgood: assert property (@(posedge clk) disable iff (!rst_n)
    ov |-> !pgood);

  a_r4_pgood_needs_rails: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && !inhibit) |-> $past(rail_a_ok && rail_b_ok));

  a_r6_pgood_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && !inhibit) |->
      (32'($past(sense_mv)) >= vidmon_pkg::pct_floor(32'(ref_mv), LO_PCT - HYS_PCT)) &&
      (32'($past(sense_mv)) <= vidmon_pkg::pct_floor(32'(ref_mv), HI_PCT)));

  a_r2_ref_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !inhibit) |->
      (ref_mv >= MV_W'(1800) && ref_mv <= MV_W'(3500) && (32'(ref_mv) % 50) == 0));

  a_r9_one_clock_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (inhibit == vidmon_pkg::code_inhibits($past(vid))));
endmodule

bind vid_pgood_mon vid_pgood_mon_chk #(
  .MV_W(MV_W), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT), .HYS_PCT(HYS_PCT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vid(vid), .sense_mv(sense_mv),
  .rail_a_ok(rail_a_ok), .rail_b_ok(rail_b_ok), .ref_mv(ref_mv),
  .inhibit(inhibit), .pgood(pgood), .ov(ov)
);

// File: tb/vid_pgood_mon_bench.sv
`timescale 1ns/1ps
module vid_pgood_mon_bench;
  localparam int MV_W = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      vid = 5'b00000;
  logic [MV_W-1:0] sense_mv = '0;
  logic            rail_a_ok = 1'b1;
  logic            rail_b_ok = 1'b1;
  logic [MV_W-1:0] ref_mv;
  logic            inhibit, pgood, ov;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  bit m_hi = 0, m_lo = 0, m_pg = 0, m_ov = 0, m_inh = 0;
  int m_ref = 0;

  always #5 clk = ~clk;

  vid_pgood_mon u_vid_pgood_mon (
    .clk(clk), .rst_n(rst_n), .vid(vid), .sense_mv(sense_mv),
    .rail_a_ok(rail_a_ok), .rail_b_ok(rail_b_ok),
    .ref_mv(ref_mv), .inhibit(inhibit), .pgood(pgood), .ov(ov)
  );

  function automatic bit exp_inh(input logic [4:0] v);
    if (v == 5'd31) return 1;
    if (v >= 5'd8 && v <= 5'd15) return 1;
    if (v == 5'd6 || v == 5'd7) return 1;
    return 0;
  endfunction

  function automatic int exp_ref(input logic [4:0] v);
    if (exp_inh(v)) return 0;
    if (v >= 5'd16) return 2100 + (30 - int'(v)) * 100;
    return 1800 + (5 - int'(v)) * 50;
  endfunction

  function automatic int pct(input int r, input int p);
    return (r * p) / 100;
  endfunction

  task automatic model_edge();
    int r, s;
    r = exp_ref(vid);
    s = int'(sense_mv);
    m_inh = exp_inh(vid);
    m_ref = r;
    if (m_inh) begin
      m_hi = 0; m_lo = 0; m_pg = 1; m_ov = 0;
    end else begin
      if (s > pct(r, 110)) m_hi = 1; else if (s < pct(r, 108)) m_hi = 0;
      if (s > pct(r, 94))  m_lo = 1; else if (s < pct(r, 92))  m_lo = 0;
      m_pg = m_lo && !m_hi && rail_a_ok && rail_b_ok;
      m_ov = s > pct(r, 115);
    end
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d (vid=%b sense=%0d)",
               tag, what, act, exp, vid, sense_mv);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    cmp(tag, "ref_mv", int'(ref_mv), m_ref);
    cmp(tag, "inhibit", int'(inhibit), int'(m_inh));
    cmp(tag, "pgood", int'(pgood), int'(m_pg));
    cmp(tag, "ov", int'(ov), int'(m_ov));
  endtask

  task automatic drive(input logic [4:0] v, input int s, input string tag);
    vid = v;
    sense_mv = MV_W'(s);
    step(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R8 reset state
    repeat (3) @(posedge clk);
    #1;
    cmp("R8", "ref_mv", int'(ref_mv), 0);
    cmp("R8", "inhibit", int'(inhibit), 0);
    cmp("R8", "pgood", int'(pgood), 0);
    cmp("R8", "ov", int'(ov), 0);
    rst_n = 1'b1;

    // every code at its nominal level: R1, R2, R3
    for (int c = 0; c < 32; c++) begin
      logic [4:0] cv;
      cv = 5'(c);
      if (exp_inh(cv)) drive(cv, 2000, "R3");
      else if (cv[4]) drive(cv, exp_ref(cv), "R2");
      else drive(cv, exp_ref(cv), "R1");
    end

    // hysteresis and boundaries at 2050 mV: R5 R6 R7 R10
    drive(5'b00000, 2050, "R1");
    drive(5'b00000, 2255, "R10");
    drive(5'b00000, 2256, "R5");
    drive(5'b00000, 2230, "R5");
    drive(5'b00000, 2214, "R10");
    drive(5'b00000, 2213, "R5");
    drive(5'b00000, 1900, "R6");
    drive(5'b00000, 1886, "R10");
    drive(5'b00000, 1885, "R6");
    drive(5'b00000, 1927, "R10");
    drive(5'b00000, 1928, "R6");
    drive(5'b00000, 2357, "R7");
    drive(5'b00000, 2358, "R7");
    drive(5'b00000, 2300, "R7");
    drive(5'b00000, 2050, "R5");

    // rail flags: R4
    rail_a_ok = 1'b0; drive(5'b00000, 2050, "R4");
    rail_a_ok = 1'b1; drive(5'b00000, 2050, "R4");
    rail_b_ok = 1'b0; drive(5'b00000, 2050, "R4");
    rail_b_ok = 1'b1; drive(5'b00000, 2050, "R4");

    // code change moves window under held sense: R9
    drive(5'b00000, 2256, "R9");
    drive(5'b11110, 2256, "R9");
    drive(5'b01100, 2256, "R9");
    drive(5'b11110, 2256, "R9");

    // random walk
    for (int i = 0; i < 4000; i++) begin
      int r, s;
      if (($urandom % 16) == 0) vid = 5'($urandom % 32);
      r = exp_ref(vid);
      if (r == 0) r = 2500;
      s = (r * (80 + int'($urandom % 45))) / 100 + int'($urandom % 3) - 1;
      rail_a_ok = ($urandom % 20) != 0;
      rail_b_ok = ($urandom % 20) != 0;
      sense_mv = MV_W'(s);
      step("R9");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule